// File: doc/BRIEF.md
# Low-Power Tamper Debouncer Array

This block watches a small set of external pins while the chip is asleep. Each pin has a role. In the tamper role, the pin must stay high for several consecutive low-rate timing pulses before it counts as a tamper event. Those pulses come in on a tick input that a real-time clock drives. A confirmed event sets a sticky per-pin tamper flag, and any set flag holds the system wake-up request high. In the wake-up role the pin has no debouncing. It raises the wake-up request directly whenever its own wake-up enable is set.

Each pin has a 3-bit period code. Code 0 turns the pin's debouncer off. Code n (1 to 7) requires the pin to be seen high on n+1 consecutive ticks. Software clears a flag by pulsing the matching bit of a write-one-to-clear input. Bus access and the generation of the tick are outside this block.

Top module: `tamper_debounce_array`

## Requirements
- R1: After reset every tamper flag is 0, and with all pins low the wake-up output is 0.
- R2: A pin is armed when its tamper enable is 1 and its period code n is from 1 to 7. For an armed pin held high, the flag stays 0 after n ticks. It becomes 1 at the clock edge that samples the (n+1)th consecutive tick seen high.
- R3: The count advances only on cycles where the tick input is 1. The pin level on cycles without a tick has no effect on the count.
- R4: If a tick samples the pin low, that pin's count returns to zero. A fresh run of n+1 high ticks is then needed.
- R5: A tamper-enabled pin with period code 0 never sets its flag.
- R6: A pin whose tamper enable is 0 never sets its flag. While its wake-up enable is 1, the wake-up output follows the pin level combinationally. While its wake-up enable is 0, the pin has no effect on the wake-up output.
- R7: A set flag stays set until its bit of the clear input is 1 on a clock edge. Clearing one bit leaves the other flags alone. If an armed pin is still high when its flag is cleared, the flag sets again on the next tick.
- R8: The wake-up output is the OR of all tamper flags and of every pin that has a wake-up enable of 1 and a tamper enable of 0. The raw level of a tamper-enabled pin does not drive the wake-up output.
- R9: Pin i uses bits [3i+2:3i] of the period-code vector and bit i of each enable vector, clear vector and flag vector. The pins do not interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per real-time-clock output period |
| pinIn | input | 5 | Pin levels, active high |
| periodCode | input | 15 | Per-pin 3-bit debounce codes, pin i at [3i+2:3i] |
| tamperEn | input | 5 | Per-pin tamper role select |
| wakeEn | input | 5 | Per-pin enable for the plain wake-up role |
| flagClr | input | 5 | Write-one-to-clear pulses for the tamper flags |
| tamperFlag | output | 5 | Sticky per-pin tamper flags |
| wakeReq | output | 1 | System wake-up request |

## Verification
The bench measures the debounce length for every code from 1 to 7. An off-by-one design would set the flag one tick early or one tick late. It holds a pin high with no ticks and drops the pin between ticks. A design that counted clock cycles, or sampled the pin outside ticks, would either set the flag too soon or lose its count. It checks that code 0 and the wake-up role stay silent, and that a tamper-enabled pin's raw level does not leak into the wake-up output. It also clears a flag while the pin is still high, which shows whether a set on that edge is dropped, and it places a short code on only the top pin to show whether the code fields are mapped to the wrong pins.

// File: rtl/tdb_pkg.sv
package tdb_pkg;
  // Per-pin strobes from control to datapath.
  typedef struct packed {
    logic inc;  // advance the consecutive-high count
    logic clr;  // return the count to zero
    logic hit;  // debounce satisfied on this edge
  } pinStrobe_t;
endpackage

// File: rtl/tdb_ctrl.sv
module tdb_ctrl
  import tdb_pkg::*;
#(
  parameter int NUM_PINS = 5,
  parameter int CODE_W   = 3,
  localparam int CNT_W   = CODE_W + 1
) (
  input  logic                         tick,
  input  logic [NUM_PINS-1:0]          pinIn,
  input  logic [NUM_PINS*CODE_W-1:0]   periodCode,
  input  logic [NUM_PINS-1:0]          tamperEn,
  input  logic [NUM_PINS*CNT_W-1:0]    cnt,
  output pinStrobe_t [NUM_PINS-1:0]    strobe
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  curCnt;
    logic [CNT_W-1:0]  nextCnt;
    logic [CNT_W-1:0]  target;
    logic              armed;

    always_comb begin
      code    = periodCode[i*CODE_W +: CODE_W];
      curCnt  = cnt[i*CNT_W +: CNT_W];
      armed   = tamperEn[i] && (code != '0);
      target  = {1'b0, code} + CNT_W'(1);
      nextCnt = (curCnt == CNT_MAX) ? curCnt : curCnt + CNT_W'(1);
      strobe[i].inc = armed && tick && pinIn[i];
      strobe[i].clr = !armed || (tick && !pinIn[i]);
      strobe[i].hit = armed && tick && pinIn[i] && (nextCnt >= target);
    end
  end
endmodule

// File: rtl/tdb_datapath.sv
module tdb_datapath
  import tdb_pkg::*;
#(
  parameter int NUM_PINS = 5,
  parameter int CODE_W   = 3,
  localparam int CNT_W   = CODE_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pinStrobe_t [NUM_PINS-1:0]  strobe,
  input  logic [NUM_PINS-1:0]        flagClr,
  input  logic [NUM_PINS-1:0]        pinIn,
  input  logic [NUM_PINS-1:0]        tamperEn,
  input  logic [NUM_PINS-1:0]        wakeEn,
  output logic [NUM_PINS*CNT_W-1:0]  cnt,
  output logic [NUM_PINS-1:0]        tamperFlag,
  output logic                       wakeReq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (strobe[i].clr) begin
        cntQ <= '0;
      end else if (strobe[i].inc && cntQ != CNT_MAX) begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end

    // A set on the same edge as a clear wins, so no event is lost.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tamperFlag[i] <= 1'b0;
      end else if (strobe[i].hit) begin
        tamperFlag[i] <= 1'b1;
      end else if (flagClr[i]) begin
        tamperFlag[i] <= 1'b0;
      end
    end

    assign cnt[i*CNT_W +: CNT_W] = cntQ;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      tamperFlag[i] && !flagClr[i] |=> tamperFlag[i]); // R7
  end

  assign wakeReq = (|tamperFlag) || (|(pinIn & wakeEn & ~tamperEn));
endmodule

// File: rtl/tamper_debounce_array.sv
module tamper_debounce_array
  import tdb_pkg::*;
#(
  parameter int NUM_PINS = 5,
  parameter int CODE_W   = 3,
  localparam int CNT_W   = CODE_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tick,
  input  logic [NUM_PINS-1:0]        pinIn,
  input  logic [NUM_PINS*CODE_W-1:0] periodCode,
  input  logic [NUM_PINS-1:0]        tamperEn,
  input  logic [NUM_PINS-1:0]        wakeEn,
  input  logic [NUM_PINS-1:0]        flagClr,
  output logic [NUM_PINS-1:0]        tamperFlag,
  output logic                       wakeReq
);
  pinStrobe_t [NUM_PINS-1:0]  strobe;
  logic [NUM_PINS*CNT_W-1:0]  cnt;

  tdb_ctrl #(.NUM_PINS(NUM_PINS), .CODE_W(CODE_W)) u_ctrl (
    .tick       (tick),
    .pinIn      (pinIn),
    .periodCode (periodCode),
    .tamperEn   (tamperEn),
    .cnt        (cnt),
    .strobe     (strobe)
  );

  tdb_datapath #(.NUM_PINS(NUM_PINS), .CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .flagClr    (flagClr),
    .pinIn      (pinIn),
    .tamperEn   (tamperEn),
    .wakeEn     (wakeEn),
    .cnt        (cnt),
    .tamperFlag (tamperFlag),
    .wakeReq    (wakeReq)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
      !tamperFlag[i] && !tick |=> !tamperFlag[i]); // R3
    AST_FLAG_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      !tamperFlag[i] && !pinIn[i] |=> !tamperFlag[i]); // R4
    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !tamperFlag[i] && (!tamperEn[i] || periodCode[i*CODE_W +: CODE_W] == '0)
      |=> !tamperFlag[i]); // R5
  end

  AST_WAKE_COVERS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (|tamperFlag) |-> wakeReq); // R8
endmodule

// File: tb/tamper_debounce_array_bench.sv
module tamper_debounce_array_bench;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tick = 1'b0;
  logic [N-1:0] pinIn = '0;
  logic [3*N-1:0] periodCode = '0;
  logic [N-1:0] tamperEn = '0;
  logic [N-1:0] wakeEn = '0;
  logic [N-1:0] flagClr = '0;
  logic [N-1:0] tamperFlag;
  logic         wakeReq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  tamper_debounce_array u_tamper_debounce_array (
    .clk(clk), .rstN(rstN), .tick(tick), .pinIn(pinIn),
    .periodCode(periodCode), .tamperEn(tamperEn), .wakeEn(wakeEn),
    .flagClr(flagClr), .tamperFlag(tamperFlag), .wakeReq(wakeReq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doTick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic quiesce();
    @(negedge clk);
    pinIn = '0; tamperEn = '0; wakeEn = '0; periodCode = '0;
    flagClr = '1;
    @(negedge clk) flagClr = '0;
    doTick(1);
  endtask

  task automatic t_reset();
    check(tamperFlag == '0, "R1 flags", int'(tamperFlag), 0);
    check(wakeReq == 1'b0, "R1 wake", int'(wakeReq), 0);
  endtask

  task automatic t_period(input int pin, input int code);
    quiesce();
    periodCode[3*pin +: 3] = 3'(code);
    tamperEn[pin] = 1'b1;
    pinIn[pin] = 1'b1;
    doTick(code);
    check(tamperFlag[pin] == 1'b0, $sformatf("R2 early pin%0d code%0d", pin, code),
          int'(tamperFlag[pin]), 0);
    doTick(1);
    check(tamperFlag == 5'(1 << pin), $sformatf("R2 set pin%0d code%0d", pin, code),
          int'(tamperFlag), 1 << pin);
  endtask

  task automatic t_tick_gate();
    quiesce();
    periodCode[5:3] = 3'd2;
    tamperEn[1] = 1'b1;
    pinIn[1] = 1'b1;
    idle(20);
    check(tamperFlag[1] == 1'b0, "R3 no ticks no flag", int'(tamperFlag[1]), 0);
    doTick(2);
    pinIn[1] = 1'b0;
    idle(5);
    pinIn[1] = 1'b1;
    doTick(1);
    check(tamperFlag[1] == 1'b1, "R3 low between ticks ignored", int'(tamperFlag[1]), 1);
  endtask

  task automatic t_low_resets();
    quiesce();
    periodCode[8:6] = 3'd3;
    tamperEn[2] = 1'b1;
    pinIn[2] = 1'b1;
    doTick(3);
    pinIn[2] = 1'b0;
    doTick(1);
    pinIn[2] = 1'b1;
    doTick(3);
    check(tamperFlag[2] == 1'b0, "R4 count restarted", int'(tamperFlag[2]), 0);
    doTick(1);
    check(tamperFlag[2] == 1'b1, "R4 fresh run sets", int'(tamperFlag[2]), 1);
  endtask

  task automatic t_code0();
    quiesce();
    tamperEn[3] = 1'b1;
    pinIn[3] = 1'b1;
    doTick(12);
    check(tamperFlag == '0, "R5 code0 silent", int'(tamperFlag), 0);
    check(wakeReq == 1'b0, "R5 code0 no wake", int'(wakeReq), 0);
  endtask

  task automatic t_wake_role();
    quiesce();
    periodCode[2:0] = 3'd1;
    wakeEn[0] = 1'b1;
    pinIn[0] = 1'b1;
    #1;
    check(wakeReq == 1'b1, "R6 wake follows pin", int'(wakeReq), 1);
    doTick(10);
    check(tamperFlag == '0, "R6 wake role no flag", int'(tamperFlag), 0);
    wakeEn[0] = 1'b0;
    #1;
    check(wakeReq == 1'b0, "R6 wake disabled", int'(wakeReq), 0);
    wakeEn[0] = 1'b1;
    pinIn[0] = 1'b0;
    #1;
    check(wakeReq == 1'b0, "R6 pin low no wake", int'(wakeReq), 0);
  endtask

  task automatic t_raw_no_wake();
    quiesce();
    periodCode[11:9] = 3'd4;
    tamperEn[3] = 1'b1;
    wakeEn[3] = 1'b1;
    pinIn[3] = 1'b1;
    idle(3);
    check(wakeReq == 1'b0, "R8 tamper pin raw level", int'(wakeReq), 0);
  endtask

  task automatic t_sticky();
    quiesce();
    periodCode[14:12] = 3'd1;
    tamperEn[4] = 1'b1;
    pinIn[4] = 1'b1;
    doTick(2);
    pinIn[4] = 1'b0;
    doTick(3);
    check(tamperFlag[4] == 1'b1, "R7 sticky", int'(tamperFlag[4]), 1);
    check(wakeReq == 1'b1, "R8 flag drives wake", int'(wakeReq), 1);
    flagClr = 5'b00001;
    @(negedge clk) flagClr = '0;
    check(tamperFlag == 5'b10000, "R7 other clear ignored", int'(tamperFlag), 16);
    flagClr = 5'b10000;
    @(negedge clk) flagClr = '0;
    check(tamperFlag == '0, "R7 cleared", int'(tamperFlag), 0);
    check(wakeReq == 1'b0, "R8 wake drops", int'(wakeReq), 0);
    pinIn[4] = 1'b1;
    doTick(2);
    check(tamperFlag[4] == 1'b1, "R7 set again", int'(tamperFlag[4]), 1);
    flagClr = 5'b10000;
    @(negedge clk) flagClr = '0;
    check(tamperFlag[4] == 1'b0, "R7 clear while high", int'(tamperFlag[4]), 0);
    doTick(1);
    check(tamperFlag[4] == 1'b1, "R7 reset on next tick", int'(tamperFlag[4]), 1);
    flagClr = 5'b10000;
    tick = 1'b1;
    @(negedge clk);
    flagClr = '0;
    tick = 1'b0;
    check(tamperFlag[4] == 1'b1, "R7 set beats clear", int'(tamperFlag[4]), 1);
  endtask

  task automatic t_field_map();
    quiesce();
    periodCode = {3'd1, 3'd7, 3'd7, 3'd7, 3'd7};
    tamperEn = '1;
    pinIn = '1;
    doTick(2);
    check(tamperFlag == 5'b10000, "R9 field map", int'(tamperFlag), 16);
  endtask

  initial begin
    idle(2);
    t_reset();
    @(negedge clk) rstN = 1'b1;
    idle(1);
    t_reset();
    for (int c = 1; c <= 7; c++) t_period(c % N, c);
    t_tick_gate();
    t_low_resets();
    t_code0();
    t_wake_role();
    t_raw_no_wake();
    t_sticky();
    t_field_map();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule